// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block makes the oversampling strobe for a UART. It divides a reference clock by a 16-bit integer divisor N plus a fraction F/64. An optional divide-by-4 prescaler can sit in front of the divider. The result is a one-clock-wide `samp_tick` at 16 or 8 times the bit rate. The same strobe drives both the transmit and receive paths. A second strobe, `bit_tick`, marks every 16th or 8th sample strobe, which gives the bit boundary for the selected oversample mode.

Software writes four byte-wide registers through a plain write port and can read them back through a combinational read port. To carry the fraction, a 6-bit phase accumulator adds F once per output period. A period is N prescaled clocks long, or N+1 when that add carries. Over 64 periods the average division is therefore N + F/64. Any register write restarts the prescaler, the divider, the accumulator and the bit counter, so a new setting takes effect from a clean phase. A divisor of zero stops all strobes.

With a 1.8432 MHz reference, no prescaler and 16x mode, N = 12 gives 9600 baud and N = 3 gives 38400 baud.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor and fraction are zero, the prescaler is off and 16x mode is selected. Every register reads 0x00 and no strobe occurs.
- R2: The register map has four addresses. Address 0 holds divisor bits 7:0 and address 1 holds divisor bits 15:8. Address 2 holds the fraction in bits 5:0 and the mode in bit 7 (1 = 8x, 0 = 16x); its bit 6 always reads 0. Address 3 bit 0 enables the prescaler and its other bits read 0.
- R3: With F = 0 and the prescaler off, `samp_tick` is high in cycle N after the last register write, and in every N-th cycle after that (the write-edge cycle is cycle 0).
- R4: With fraction F, the first 64 periods after a write include exactly F periods of N+1 prescaled clocks. The rest are N long, so the 64th strobe falls in cycle 64N+F.
- R5: With the prescaler on, one prescaled clock is four reference clocks. The first one completes in cycle 4 after a write, so strobe k falls in cycle 4·(kN + carries).
- R6: While the divisor is zero, neither `samp_tick` nor `bit_tick` is ever asserted.
- R7: `bit_tick` is asserted only together with `samp_tick`. It marks every 16th sample strobe in 16x mode and every 8th in 8x mode.
- R8: Any register write, even one that rewrites an unchanged value, restarts the timing. The next strobe then follows the R3/R5 timing measured from that write.
- R9: The divisor spans both bytes. For example, N = 258 (high byte 1, low byte 2) yields one strobe per 258 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| samp_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle bit-boundary strobe |

## Verification
The divider is driven with plain integer divisors (N = 1, 3, 12, 258) and with fractions at the edges of the range (21, 32, 63). The fraction is also combined with the prescaler and with both oversample modes. Strobe counts over a window that ends exactly on the predicted 64th strobe separate errors in period length, carry placement and prescale ratio. A per-interval histogram for N = 5, F = 21 separates the right number of long periods from a correct average reached the wrong way. Directed cases cover reset values, the reserved bits, the zero divisor, and a restart caused by rewriting an unchanged value.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int DIV_W  = 16;
  localparam int FRAC_W = 6;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DIV_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd2;
  localparam logic [ADDR_W-1:0] A_PRESC  = 2'd3;

  localparam int MODE_BIT = 7;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [FRAC_W-1:0] frac;
    logic              mode8;
    logic              presc;
  } fbg_cfg_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output fbg_cfg_t          cfg,
  output logic              restart
);
  localparam int HALF = DIV_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_DIV_LO: cfg.div[HALF-1:0]     <= wr_data[HALF-1:0];
        A_DIV_HI: cfg.div[DIV_W-1:HALF] <= wr_data[HALF-1:0];
        A_MODE: begin
          cfg.frac  <= wr_data[FRAC_W-1:0];
          cfg.mode8 <= wr_data[MODE_BIT];
        end
        default:  cfg.presc <= wr_data[0];
      endcase
    end
  end

  assign restart = wr_en;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_DIV_LO: rd_data = cfg.div[HALF-1:0];
      A_DIV_HI: rd_data = cfg.div[DIV_W-1:HALF];
      A_MODE: begin
        rd_data[FRAC_W-1:0] = cfg.frac;
        rd_data[MODE_BIT]   = cfg.mode8;
      end
      default:  rd_data[0] = cfg.presc;
    endcase
  end

  // R2: a write to the mode register lands its fraction field next cycle
  a_r2_frac_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE) |=> cfg.frac == $past(wr_data[FRAC_W-1:0]));
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable_div,
  output logic clk_en
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || !enable_div) cnt <= '0;
    else if (cnt == LAST)         cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign clk_en = enable_div ? (cnt == LAST) : 1'b1;

  // R5: when dividing, enables are spaced, never in consecutive cycles
  a_r5_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_div && clk_en && !restart) |=> !clk_en || !enable_div || restart);
endmodule

// File: rtl/fbg_phase_div.sv
module fbg_phase_div #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              clk_en,
  input  logic [DIV_W-1:0]  div,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);
  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              carry;
  logic [DIV_W:0]    limit;
  logic              active;
  logic              hit;

  assign sum    = {1'b0, acc} + {1'b0, frac};
  assign carry  = sum[FRAC_W];
  assign active = (div != '0);
  assign limit  = {1'b0, div} - 1'b1 + {{DIV_W{1'b0}}, carry};
  assign hit    = ({1'b0, cnt} == limit);
  assign tick   = clk_en && active && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (restart || !active) begin
      cnt <= '0;
      acc <= '0;
    end else if (clk_en) begin
      if (hit) begin
        cnt <= '0;
        acc <= sum[FRAC_W-1:0];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: a write leaves the divider at a clean phase
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && acc == '0));
  // R4: the period counter never passes the current period length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, cnt} <= limit));
endmodule

// File: rtl/fbg_bit_strobe.sv
module fbg_bit_strobe #(
  parameter int OSR_HI = 16,
  parameter int OSR_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic mode8,
  input  logic samp_tick,
  output logic bit_tick
);
  localparam int CW = $clog2(OSR_HI);
  localparam logic [CW-1:0] LAST_HI = CW'(OSR_HI - 1);
  localparam logic [CW-1:0] LAST_LO = CW'(OSR_LO - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last     = mode8 ? LAST_LO : LAST_HI;
  assign bit_tick = samp_tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (samp_tick)      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int PRESC_RATIO = 4,
  parameter int OSR_HI      = 16,
  parameter int OSR_LO      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              samp_tick,
  output logic              bit_tick
);
  fbg_cfg_t cfg;
  logic     restart;
  logic     clk_en;

  fbg_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg(cfg), .restart(restart)
  );

  fbg_prescaler #(.RATIO(PRESC_RATIO)) presc_i (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .enable_div(cfg.presc), .clk_en(clk_en)
  );

  fbg_phase_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) div_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .clk_en(clk_en),
    .div(cfg.div), .frac(cfg.frac), .tick(samp_tick)
  );

  fbg_bit_strobe #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) bit_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .mode8(cfg.mode8),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.div == '0) |-> (!samp_tick && !bit_tick));
  a_r7_bit_in_samp: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);
  a_r5_tick_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |-> clk_en);
endmodule

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       samp_tick;
  logic       bit_tick;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frac_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  typedef struct packed {
    logic [15:0] div;
    logic [5:0]  frac;
    logic        presc;
    logic        mode8;
    logic [15:0] window;
    logic [7:0]  exp_s;
    logic [7:0]  exp_b;
  } vec_t;

  // window = cycle of the predicted last strobe (R3/R4/R5/R9)
  localparam vec_t VECS [7] = '{
    '{16'd3,   6'd0,  1'b0, 1'b0, 16'd192,  8'd64, 8'd4},
    '{16'd12,  6'd0,  1'b0, 1'b1, 16'd768,  8'd64, 8'd8},
    '{16'd5,   6'd21, 1'b0, 1'b0, 16'd341,  8'd64, 8'd4},
    '{16'd2,   6'd63, 1'b1, 1'b0, 16'd764,  8'd64, 8'd4},
    '{16'd258, 6'd0,  1'b0, 1'b1, 16'd4128, 8'd16, 8'd2},
    '{16'd1,   6'd0,  1'b0, 1'b0, 16'd64,   8'd64, 8'd4},
    '{16'd1,   6'd32, 1'b0, 1'b1, 16'd96,   8'd64, 8'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // samples cycles 1..w after the last write (caller sits at cycle 1)
  task automatic count_win(input int w, output int s, output int b);
    s = 0; b = 0;
    for (int i = 0; i < w; i++) begin
      if (samp_tick) s++;
      if (bit_tick) b++;
      @(negedge clk);
    end
  endtask

  task automatic first_tick(input int limit, output int at);
    at = -1;
    for (int i = 1; i <= limit; i++) begin
      if (samp_tick && at < 0) at = i;
      @(negedge clk);
    end
  endtask

  initial begin
    int s, b, v, lng, sht, oth, len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values and silence
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset read", v, 0);
    end
    count_win(300, s, b);
    chk("R1 no samp after reset", s, 0);
    chk("R1 no bit after reset", b, 0);

    // R1/R7: default 16x with only the low divisor byte written
    wr(2'd0, 8'd4);
    count_win(128, s, b);
    chk("R1 default samp count", s, 32);
    chk("R1 default 16x bit count", b, 2);

    // table walk: R3 R4 R5 R7 R9
    foreach (VECS[k]) begin
      wr(2'd3, {7'd0, VECS[k].presc});
      wr(2'd1, VECS[k].div[15:8]);
      wr(2'd2, {VECS[k].mode8, 1'b0, VECS[k].frac});
      wr(2'd0, VECS[k].div[7:0]);
      count_win(int'(VECS[k].window), s, b);
      chk($sformatf("R3/R4/R5/R9 vec%0d samp", k), s, int'(VECS[k].exp_s));
      chk($sformatf("R7 vec%0d bit", k), b, int'(VECS[k].exp_b));
    end

    // R4: interval histogram for N=5, F=21
    wr(2'd3, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd21); wr(2'd0, 8'd5);
    lng = 0; sht = 0; oth = 0; len = 0;
    for (int p = 0; p < 64; ) begin
      len++;
      if (samp_tick) begin
        if (len == 6) lng++; else if (len == 5) sht++; else oth++;
        len = 0;
        p++;
      end
      @(negedge clk);
    end
    chk("R4 long periods", lng, 21);
    chk("R4 short periods", sht, 43);
    chk("R4 other periods", oth, 0);

    // R2: reserved bits and readback
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R2 mode reg reserved bit6", v, 8'hBF);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R2 prescaler reg upper bits", v, 8'h01);
    wr(2'd1, 8'hA5);
    rd(2'd1, v); chk("R2 divisor high byte", v, 8'hA5);

    // R8: rewrite unchanged value mid-period restarts timing
    wr(2'd3, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd0, 8'd10);
    count_win(25, s, b);
    chk("R8 pre-rewrite ticks", s, 2);
    wr(2'd0, 8'd10);
    first_tick(15, v);
    chk("R8 first tick after rewrite", v, 10);

    // R6: zero divisor silences everything
    wr(2'd2, 8'h80); wr(2'd0, 8'd0);
    count_win(500, s, b);
    chk("R6 zero divisor samp", s, 0);
    chk("R6 zero divisor bit", b, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule